// File: doc/BRIEF.md
# Triggered-Conversion ADC Read Controller

This block drives a 12-bit serial analog-to-digital converter that starts a conversion on a falling edge of its active-low start line and then returns its result over a three-wire serial link. On a one-cycle start request, or on its own at a fixed repeat interval, the controller pulls the start line low for a short pulse. It then waits out the converter's worst-case conversion time and clocks sixteen serial bits in. After the last bit it holds a quiet gap before a new conversion may begin.

The serial clock is kept low at every moment outside the read window, so it is low while the start line falls and throughout the conversion. The first four bits of each frame must be zero. They are checked, raise an error flag if any is set, and are then dropped. The last twelve bits, most significant first, form a two's-complement result that is presented with a single-cycle strobe. All timing figures are parameters counted in system clock cycles. The defaults suit a 50 MHz system clock: a 12.5 MHz serial clock, 3.4 us of conversion wait and a 100 ns quiet gap.

Top module: `adc_conv_reader`

## Requirements
- R1: During and just after reset, `convst_n_o` is 1, `sclk_o` is 0, `valid_o` is 0, `result_o` is 0 and `frame_err_o` is 0.
- R2: A start taken in the idle state drives `convst_n_o` low from the next cycle for exactly `CONVST_LOW` cycles.
- R3: The first rising edge of `sclk_o` in a frame comes exactly `CONV_CYCLES` cycles after the first cycle in which `convst_n_o` is low.
- R4: `sclk_o` is 0 in every cycle outside the read window, and in particular whenever `convst_n_o` is 0.
- R5: A read has exactly 16 serial clock pulses, back to back. Each pulse is high for `SCLK_HALF` cycles and then low for `SCLK_HALF` cycles.
- R6: `sdata_i` is sampled in the last system cycle of each high phase of `sclk_o`. The 12 bits sampled on pulses 5 to 16 become `result_o`, and the bit from pulse 5 is the MSB (sign bit).
- R7: `frame_err_o` is 1 with a result when any of the bits sampled on pulses 1 to 4 is 1, and 0 otherwise.
- R8: `valid_o` is high for exactly one cycle per conversion. That cycle comes right after the low phase of the 16th pulse ends. `result_o` and `frame_err_o` change only in that cycle and hold their values until the next one.
- R9: The next cycle with `convst_n_o` low comes no earlier than `QUIET_CYCLES`+1 cycles after the `valid_o` cycle.
- R10: `start_i` has no effect while a conversion, read or quiet gap is in progress. Holding it high yields one frame per idle slot, not extra falls of `convst_n_o`.
- R11: With `auto_en_i` high, conversions repeat without `start_i`. Falls of `convst_n_o` are spaced exactly `PERIOD_CYCLES` cycles apart, provided one frame fits in that interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request one conversion (taken only when idle) |
| auto_en_i | input | 1 | Enable repeating conversions at the set interval |
| sdata_i | input | 1 | Serial data from the converter |
| convst_n_o | output | 1 | Active-low conversion start to the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| result_o | output | 12 | Last two's-complement result |
| frame_err_o | output | 1 | Leading bits of the last frame were not all zero |
| valid_o | output | 1 | One-cycle strobe marking a new result |

## Verification
The bound checker watches, on every cycle, the rules that hold on their own: the serial clock stays low while the start line is low, the start pulse has its set width, and the first serial edge comes exactly at the end of the conversion wait. It also checks that each strobe follows exactly sixteen pulses, that the strobe lasts one cycle with the result held between strobes, and that the quiet gap comes before each new start. Some behaviour can only be shown by the bench's scenarios with a modelled converter. These are the bit order and sign of the assembled word, the error flag for particular leading patterns, the fact that start requests during a busy frame are ignored, and the exact spacing of repeated conversions.

// File: rtl/adc_conv_reader.sv
module adc_conv_reader #(
  parameter int SCLK_HALF     = 2,
  parameter int CONVST_LOW    = 3,
  parameter int CONV_CYCLES   = 170,
  parameter int QUIET_CYCLES  = 5,
  parameter int PERIOD_CYCLES = 300,
  parameter int FRAME_BITS    = 16,
  parameter int DATA_BITS     = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 auto_en_i,
  input  logic                 sdata_i,
  output logic                 convst_n_o,
  output logic                 sclk_o,
  output logic [DATA_BITS-1:0] result_o,
  output logic                 frame_err_o,
  output logic                 valid_o
);
  localparam int CW = $clog2(CONV_CYCLES + QUIET_CYCLES + PERIOD_CYCLES + 2);
  localparam int PW = $clog2(2 * SCLK_HALF) < 1 ? 1 : $clog2(2 * SCLK_HALF);
  localparam int BW = $clog2(FRAME_BITS);

  typedef enum logic [2:0] {S_IDLE, S_LOW, S_CONV, S_READ, S_QUIET} state_t;

  state_t                st;
  logic [CW-1:0]         cnt;
  logic [CW-1:0]         per_cnt;
  logic [PW-1:0]         ph;
  logic [BW-1:0]         bit_idx;
  logic [FRAME_BITS-1:0] shreg;

  wire per_done = per_cnt == CW'(PERIOD_CYCLES - 1);
  wire go       = (st == S_IDLE) && (start_i || (auto_en_i && per_done));
  wire ph_samp  = ph == PW'(SCLK_HALF - 1);
  wire ph_last  = ph == PW'(2 * SCLK_HALF - 1);
  wire bit_last = bit_idx == BW'(FRAME_BITS - 1);

  assign convst_n_o = (st != S_LOW);
  assign sclk_o     = (st == S_READ) && (ph < PW'(SCLK_HALF));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      ph          <= '0;
      bit_idx     <= '0;
      shreg       <= '0;
      result_o    <= '0;
      frame_err_o <= 1'b0;
      valid_o     <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      case (st)
        S_IDLE: if (go) begin
          st  <= S_LOW;
          cnt <= '0;
        end
        S_LOW: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(CONVST_LOW - 1)) st <= S_CONV;
        end
        S_CONV: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(CONV_CYCLES - 1)) begin
            st      <= S_READ;
            ph      <= '0;
            bit_idx <= '0;
          end
        end
        S_READ: begin
          ph <= ph_last ? '0 : ph + 1'b1;
          if (ph_samp) shreg <= {shreg[FRAME_BITS-2:0], sdata_i};
          if (ph_last) begin
            bit_idx <= bit_idx + 1'b1;
            if (bit_last) begin
              st          <= S_QUIET;
              cnt         <= '0;
              result_o    <= shreg[DATA_BITS-1:0];
              frame_err_o <= |shreg[FRAME_BITS-1:DATA_BITS];
              valid_o     <= 1'b1;
            end
          end
        end
        S_QUIET: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(QUIET_CYCLES - 1)) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        per_cnt <= '0;
    else if (go)       per_cnt <= '0;
    else if (!per_done) per_cnt <= per_cnt + 1'b1;
  end
endmodule

// File: rtl/adc_conv_reader_chk.sv
module adc_conv_reader_chk #(
  parameter int CONVST_LOW   = 3,
  parameter int CONV_CYCLES  = 170,
  parameter int QUIET_CYCLES = 5,
  parameter int FRAME_BITS   = 16,
  parameter int DATA_BITS    = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 convst_n_o,
  input logic                 sclk_o,
  input logic                 valid_o,
  input logic [DATA_BITS-1:0] result_o,
  input logic                 frame_err_o
);
  logic [15:0] low_run, since_fall, rises, gap;
  logic        prev_cs, prev_sclk, seen_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_run    <= '0;
      since_fall <= 16'hFFFF;
      rises      <= '0;
      gap        <= '0;
      prev_cs    <= 1'b1;
      prev_sclk  <= 1'b0;
      seen_valid <= 1'b0;
    end else begin
      prev_cs   <= convst_n_o;
      prev_sclk <= sclk_o;
      low_run   <= convst_n_o ? '0 : low_run + 16'd1;
      if (!convst_n_o && prev_cs) begin
        since_fall <= 16'd1;
        rises      <= '0;
      end else begin
        if (since_fall != 16'hFFFF) since_fall <= since_fall + 16'd1;
        if (sclk_o && !prev_sclk) rises <= rises + 16'd1;
      end
      if (valid_o) begin
        gap        <= 16'd1;
        seen_valid <= 1'b1;
      end else if (gap != 16'hFFFF) gap <= gap + 16'd1;
    end
  end

  assert_sclk_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !convst_n_o |-> !sclk_o);
  assert_convst_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(convst_n_o) |-> low_run == 16'(CONVST_LOW));
  assert_first_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sclk_o) && rises == 16'd0) |-> since_fall == 16'(CONV_CYCLES));
  assert_pulse_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> rises == 16'(FRAME_BITS));
  assert_single_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(result_o) && $stable(frame_err_o)));
  assert_quiet_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(convst_n_o) && seen_valid) |-> gap >= 16'(QUIET_CYCLES + 1));
endmodule

bind adc_conv_reader adc_conv_reader_chk #(
  .CONVST_LOW(CONVST_LOW), .CONV_CYCLES(CONV_CYCLES), .QUIET_CYCLES(QUIET_CYCLES),
  .FRAME_BITS(FRAME_BITS), .DATA_BITS(DATA_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .convst_n_o(convst_n_o), .sclk_o(sclk_o),
  .valid_o(valid_o), .result_o(result_o), .frame_err_o(frame_err_o)
);

// File: tb/adc_conv_reader_test.sv
module adc_conv_reader_test;
  localparam int H = 2, LOWC = 3, CONV = 170, Q = 5, PER = 300;
  localparam int RD = 32 * H;
  localparam int E  = CONV + RD + Q;

  logic clk = 0, rst_n = 0, start_i = 0, auto_en_i = 0, sdata_i = 0;
  logic convst_n_o, sclk_o, frame_err_o, valid_o;
  logic [11:0] result_o;

  adc_conv_reader #(.SCLK_HALF(H), .CONVST_LOW(LOWC), .CONV_CYCLES(CONV),
                    .QUIET_CYCLES(Q), .PERIOD_CYCLES(PER)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .auto_en_i(auto_en_i),
    .sdata_i(sdata_i), .convst_n_o(convst_n_o), .sclk_o(sclk_o),
    .result_o(result_o), .frame_err_o(frame_err_o), .valid_o(valid_o));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  logic [15:0] word = 16'h0;
  int pc = 0;
  always @(negedge convst_n_o or posedge sclk_o or negedge sclk_o) begin
    if (!convst_n_o) pc = 0;
    else if (sclk_o) begin
      if (pc == 0) sdata_i = word[15];
    end else begin
      pc++;
      if (pc < 16) sdata_i = word[15 - pc];
    end
  end

  // reference model: cycle position in the current frame
  int cyc = 0, rel = 0, since = 0;
  bit busy = 0;
  logic [15:0] cur_word = 0;
  logic [11:0] exp_res = 0;
  logic        exp_err = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      busy = 0; rel = 0; since = 0; exp_res = 0; exp_err = 0;
    end else begin
      bit go;
      go = !busy && (start_i || (auto_en_i && since >= PER - 1));
      if (busy) begin
        rel++;
        if (rel == CONV + RD) begin
          exp_res = cur_word[11:0];
          exp_err = |cur_word[15:12];
        end
        if (rel == E) busy = 0;
      end else if (go) begin
        busy = 1; rel = 0; cur_word = word;
      end
      if (go) since = 0; else if (since < PER - 1) since++;
    end
    cyc++;
  end

  int t_fall = 0, t_valid = -1, n_fall = 0, rises = 0;
  int auto_falls[$];
  logic prev_cs = 1, prev_sclk = 0;
  always @(negedge clk) if (rst_n) begin
    bit e_cs, e_sclk, e_val;
    int r;
    e_cs   = !(busy && rel < LOWC);
    r      = rel - CONV;
    e_sclk = busy && r >= 0 && r < RD && (r % (2 * H)) < H;
    e_val  = busy && rel == CONV + RD;
    check(convst_n_o == e_cs, "R2 convst_n", convst_n_o, e_cs);
    check(sclk_o == e_sclk, e_sclk ? "R5 sclk" : "R4 sclk", sclk_o, e_sclk);
    check(valid_o == e_val, "R8 valid", valid_o, e_val);
    check(result_o == exp_res, "R6 result", result_o, exp_res);
    check(frame_err_o == exp_err, "R7 frame_err", frame_err_o, exp_err);
    if (prev_cs && !convst_n_o) begin
      t_fall = cyc; n_fall++; rises = 0;
      if (auto_en_i) auto_falls.push_back(cyc);
      if (t_valid >= 0) check(cyc - t_valid >= Q + 1, "R9 quiet gap", cyc - t_valid, Q + 1);
    end
    if (!prev_sclk && sclk_o) begin
      if (rises == 0) check(cyc - t_fall == CONV, "R3 first edge", cyc - t_fall, CONV);
      rises++;
    end
    if (valid_o) t_valid = cyc;
    prev_cs = convst_n_o; prev_sclk = sclk_o;
  end

  task automatic one(input logic [15:0] w);
    word = w;
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
    repeat (E + 2) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        check(convst_n_o == 1 && sclk_o == 0 && valid_o == 0, "R1 ctrl", {convst_n_o, sclk_o, valid_o}, 3'b100);
        check(result_o == 0 && frame_err_o == 0, "R1 data", {frame_err_o, result_o}, 0);
        one(16'h0123); one(16'h0FFF); one(16'h0800); one(16'h07FF);
        one(16'h0000); one(16'h8555); one(16'h1AAA); one(16'hF000);
        begin : r10_blk
          int f0;
          word = 16'h0A5C;
          f0 = n_fall;
          @(negedge clk) start_i = 1;
          repeat (E) @(negedge clk);
          check(n_fall - f0 == 1, "R10 ignored start", n_fall - f0, 1);
          repeat (E / 2) @(negedge clk);
          start_i = 0;
          check(n_fall - f0 == 2, "R10 one per idle slot", n_fall - f0, 2);
          repeat (E + 2) @(negedge clk);
        end
        word = 16'h0321;
        auto_en_i = 1;
        repeat (3 * PER + 20) @(negedge clk);
        auto_en_i = 0;
        repeat (E + 2) @(negedge clk);
        check(auto_falls.size() >= 3, "R11 count", auto_falls.size(), 3);
        for (int i = 1; i < auto_falls.size(); i++)
          check(auto_falls[i] - auto_falls[i-1] == PER, "R11 spacing",
                auto_falls[i] - auto_falls[i-1], PER);
      end
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule